// File: doc/BRIEF.md
# Reset-Latched Operating Mode and Port Multiplexer

This block decides, once per reset, how a controller's three 8-bit ports are used. On the first clock edge after synchronous reset is released it captures a two-bit mode code from dedicated pins. It then holds one of four operating modes until reset is asserted again. In the two single-chip modes (plain single-chip and bootstrap) the ports are general-purpose I/O. Each pin is driven from a CPU-side output register and enabled by a per-bit direction register.

In the two bus modes (expanded and test) the same pins form an external bus. One port carries the upper address byte and another carries the lower address byte. The third port is a bidirectional data port, and a read/write strobe gives the direction of each transfer. The latched mode also controls a boot ROM window. That window answers internal decodes of the top 256-byte page below 0xC000, which holds the reset and interrupt vectors at 0xBFC0 to 0xBFFF, but only in bootstrap mode.

The mode FSM has five states. `ST_RESET` is entered whenever `rst` is high. From `ST_RESET` with `rst` low, one transition per code leads to `ST_BOOT` (00), `ST_TEST` (01), `ST_SINGLE` (10) or `ST_EXPAND` (11). Each of those four states holds itself until `rst` returns the FSM to `ST_RESET`.

Top module: `portmode_ctrl`

## Requirements
- R1: While `rst` is high, and at the edge on which it is sampled high, the block is quiet. All three output enables are 0, `rw_n` is 1, `boot_sel` is 0 and `mode_valid` is 0.
- R2: On the first rising edge with `rst` low, the mode is loaded from `mode_pins` = {B,A}: 00 bootstrap, 01 test, 10 single-chip, 11 expanded. After that edge `mode_valid` is 1 and `mode_code` equals the captured code.
- R3: After the mode is latched, changes on `mode_pins` have no effect on `mode_code` or on the port behaviour until the next reset.
- R4: In single-chip and bootstrap modes each port drives its CPU-side output register and takes its output enable from its direction register (1 = output). `rw_n` is 1 and `ext_rdata` is 0.
- R5: In expanded and test modes, port B drives `cpu_addr[15:8]` and port F drives `cpu_addr[7:0]`, both with all enable bits set.
- R6: In bus modes with `cpu_we` = 1, port C drives `cpu_wdata` with all enable bits set and `rw_n` is 0. `ext_rdata` is 0.
- R7: In bus modes with `cpu_we` = 0, port C has all enable bits clear, `rw_n` is 1 and `ext_rdata` equals the sampled `pc_in`.
- R8: In bootstrap mode `boot_sel` is 1 exactly for addresses 0xBF00 to 0xBFFF, which include the vectors at 0xBFC0 to 0xBFFF.
- R9: In test, single-chip and expanded modes `boot_sel` is 0 for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_pins | input | 2 | Mode-select pins {B,A} |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| gpio_b_out | input | 8 | Port B output register |
| gpio_b_dir | input | 8 | Port B direction register |
| gpio_c_out | input | 8 | Port C output register |
| gpio_c_dir | input | 8 | Port C direction register |
| gpio_f_out | input | 8 | Port F output register |
| gpio_f_dir | input | 8 | Port F direction register |
| pc_in | input | 8 | Port C pin levels |
| pb_out | output | 8 | Port B pin value |
| pb_oe | output | 8 | Port B per-pin enable |
| pc_out | output | 8 | Port C pin value |
| pc_oe | output | 8 | Port C per-pin enable |
| pf_out | output | 8 | Port F pin value |
| pf_oe | output | 8 | Port F per-pin enable |
| rw_n | output | 1 | Bus direction, 1 = read |
| ext_rdata | output | 8 | Read data from the data port |
| boot_sel | output | 1 | Boot ROM window selected |
| mode_valid | output | 1 | A mode has been latched |
| mode_code | output | 2 | Latched mode code |

## Verification
In bootstrap mode, the boot window decode and general-purpose port driving fall in the same cycle. The bench provokes this by placing the CPU address inside 0xBF00 to 0xBFFF while the direction registers hold mixed patterns. It then checks that `boot_sel` is 1 and that every port still follows its output and direction registers, with no address leaking onto the pins. The opposite pairing is covered in expanded and test modes. There, the same window addresses appear on ports B and F, and `boot_sel` stays 0 during both reads and writes.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [2:0] {
        ST_RESET,
        ST_BOOT,
        ST_TEST,
        ST_SINGLE,
        ST_EXPAND
    } pm_state_t;
endpackage

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pins,
    output pm_state_t  state
);
    pm_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET: begin
                unique case (mode_pins)
                    2'b00: state_nx = ST_BOOT;
                    2'b01: state_nx = ST_TEST;
                    2'b10: state_nx = ST_SINGLE;
                    2'b11: state_nx = ST_EXPAND;
                    default: state_nx = ST_RESET;
                endcase
            end
            ST_BOOT, ST_TEST, ST_SINGLE, ST_EXPAND: state_nx = state;
            default: state_nx = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= state_nx;
    end
endmodule

// File: rtl/pm_port_mux.sv
module pm_port_mux
    import pm_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int ADDR_W = 2 * PORT_W
) (
    input  pm_state_t          state,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [PORT_W-1:0]  cpu_wdata,
    input  logic               cpu_we,
    input  logic [PORT_W-1:0]  gpio_b_out,
    input  logic [PORT_W-1:0]  gpio_b_dir,
    input  logic [PORT_W-1:0]  gpio_c_out,
    input  logic [PORT_W-1:0]  gpio_c_dir,
    input  logic [PORT_W-1:0]  gpio_f_out,
    input  logic [PORT_W-1:0]  gpio_f_dir,
    input  logic [PORT_W-1:0]  pc_in,
    output logic [PORT_W-1:0]  pb_out,
    output logic [PORT_W-1:0]  pb_oe,
    output logic [PORT_W-1:0]  pc_out,
    output logic [PORT_W-1:0]  pc_oe,
    output logic [PORT_W-1:0]  pf_out,
    output logic [PORT_W-1:0]  pf_oe,
    output logic               rw_n,
    output logic [PORT_W-1:0]  ext_rdata
);
    localparam logic [PORT_W-1:0] ALL_ON  = {PORT_W{1'b1}};
    localparam logic [PORT_W-1:0] ALL_OFF = {PORT_W{1'b0}};

    always_comb begin
        pb_out    = ALL_OFF;
        pb_oe     = ALL_OFF;
        pc_out    = ALL_OFF;
        pc_oe     = ALL_OFF;
        pf_out    = ALL_OFF;
        pf_oe     = ALL_OFF;
        rw_n      = 1'b1;
        ext_rdata = ALL_OFF;
        unique case (state)
            ST_RESET: begin
                rw_n = 1'b1;
            end
            ST_BOOT, ST_SINGLE: begin
                pb_out = gpio_b_out;
                pb_oe  = gpio_b_dir;
                pc_out = gpio_c_out;
                pc_oe  = gpio_c_dir;
                pf_out = gpio_f_out;
                pf_oe  = gpio_f_dir;
            end
            ST_TEST, ST_EXPAND: begin
                pb_out = cpu_addr[ADDR_W-1:PORT_W];
                pb_oe  = ALL_ON;
                pf_out = cpu_addr[PORT_W-1:0];
                pf_oe  = ALL_ON;
                rw_n   = ~cpu_we;
                if (cpu_we) begin
                    pc_out = cpu_wdata;
                    pc_oe  = ALL_ON;
                end else begin
                    ext_rdata = pc_in;
                end
            end
            default: rw_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/pm_boot_decode.sv
module pm_boot_decode
    import pm_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hBF00,
    parameter int                WIN_LOG2 = 8,
    localparam int               TAG_W    = ADDR_W - WIN_LOG2
) (
    input  pm_state_t          state,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               boot_sel
);
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

    always_comb begin
        boot_sel = 1'b0;
        unique case (state)
            ST_BOOT: boot_sel = (cpu_addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
            ST_RESET, ST_TEST, ST_SINGLE, ST_EXPAND: boot_sel = 1'b0;
            default: boot_sel = 1'b0;
        endcase
    end
endmodule

// File: rtl/portmode_ctrl.sv
module portmode_ctrl
    import pm_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int WIN_LOG2 = 8,
    localparam int ADDR_W  = 2 * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_pins,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [PORT_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic [PORT_W-1:0] gpio_b_out,
    input  logic [PORT_W-1:0] gpio_b_dir,
    input  logic [PORT_W-1:0] gpio_c_out,
    input  logic [PORT_W-1:0] gpio_c_dir,
    input  logic [PORT_W-1:0] gpio_f_out,
    input  logic [PORT_W-1:0] gpio_f_dir,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe,
    output logic [PORT_W-1:0] pf_out,
    output logic [PORT_W-1:0] pf_oe,
    output logic              rw_n,
    output logic [PORT_W-1:0] ext_rdata,
    output logic              boot_sel,
    output logic              mode_valid,
    output logic [1:0]        mode_code
);
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(16'hBF00);

    pm_state_t state;

    pm_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mode_pins (mode_pins),
        .state     (state)
    );

    pm_port_mux #(.PORT_W(PORT_W)) u_mux (
        .state      (state),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_we     (cpu_we),
        .gpio_b_out (gpio_b_out),
        .gpio_b_dir (gpio_b_dir),
        .gpio_c_out (gpio_c_out),
        .gpio_c_dir (gpio_c_dir),
        .gpio_f_out (gpio_f_out),
        .gpio_f_dir (gpio_f_dir),
        .pc_in      (pc_in),
        .pb_out     (pb_out),
        .pb_oe      (pb_oe),
        .pc_out     (pc_out),
        .pc_oe      (pc_oe),
        .pf_out     (pf_out),
        .pf_oe      (pf_oe),
        .rw_n       (rw_n),
        .ext_rdata  (ext_rdata)
    );

    pm_boot_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LOG2 (WIN_LOG2)
    ) u_boot (
        .state    (state),
        .cpu_addr (cpu_addr),
        .boot_sel (boot_sel)
    );

    // Status outputs derived from the held state.
    always_comb begin
        mode_valid = 1'b1;
        mode_code  = 2'b00;
        unique case (state)
            ST_RESET:  begin mode_valid = 1'b0; mode_code = 2'b00; end
            ST_BOOT:   mode_code = 2'b00;
            ST_TEST:   mode_code = 2'b01;
            ST_SINGLE: mode_code = 2'b10;
            ST_EXPAND: mode_code = 2'b11;
            default:   begin mode_valid = 1'b0; mode_code = 2'b00; end
        endcase
    end
endmodule

// File: rtl/portmode_ctrl_chk.sv
module portmode_ctrl_chk #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_pins,
    input logic [2*PORT_W-1:0] cpu_addr,
    input logic [PORT_W-1:0] cpu_wdata,
    input logic              cpu_we,
    input logic [PORT_W-1:0] gpio_b_dir,
    input logic [PORT_W-1:0] gpio_f_dir,
    input logic [PORT_W-1:0] pb_oe,
    input logic [PORT_W-1:0] pc_out,
    input logic [PORT_W-1:0] pc_oe,
    input logic [PORT_W-1:0] pf_oe,
    input logic              rw_n,
    input logic              boot_sel,
    input logic              mode_valid,
    input logic [1:0]        mode_code
);
    // R2: a released reset yields a valid mode on the next edge
    a_r2_latch_on_release: assert property (@(posedge clk) disable iff (rst)
        !mode_valid |=> mode_valid);

    // R3: the latched code never moves while out of reset
    a_r3_mode_held: assert property (@(posedge clk) disable iff (rst)
        mode_valid |=> $stable(mode_code));

    // R4: single-chip modes follow the direction registers
    a_r4_gpio_dir: assert property (@(posedge clk) disable iff (rst)
        (mode_valid && !mode_code[0]) |-> (pb_oe == gpio_b_dir && pf_oe == gpio_f_dir && rw_n));

    // R5: bus modes drive both address ports fully
    a_r5_addr_drive: assert property (@(posedge clk) disable iff (rst)
        (mode_valid && mode_code[0]) |-> (&pb_oe && &pf_oe));

    // R6: writes in bus modes drive data and pull the strobe low
    a_r6_write_drive: assert property (@(posedge clk) disable iff (rst)
        (mode_valid && mode_code[0] && cpu_we) |-> (&pc_oe && !rw_n && pc_out == cpu_wdata));

    // R7: reads in bus modes release the data port
    a_r7_read_release: assert property (@(posedge clk) disable iff (rst)
        (mode_valid && mode_code[0] && !cpu_we) |-> (pc_oe == '0 && rw_n));

    // R9: the boot window only answers in bootstrap mode
    a_r9_boot_only: assert property (@(posedge clk) disable iff (rst)
        boot_sel |-> (mode_valid && mode_code == 2'b00));
endmodule

bind portmode_ctrl portmode_ctrl_chk #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/portmode_ctrl_tb.sv
`timescale 1ns/1ps
module portmode_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_pins = 2'b00;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  gbo = '0, gbd = '0, gco = '0, gcd = '0, gfo = '0, gfd = '0;
    logic [7:0]  pc_in = '0;
    logic [7:0]  pb_out, pb_oe, pc_out, pc_oe, pf_out, pf_oe, ext_rdata;
    logic        rw_n, boot_sel, mode_valid;
    logic [1:0]  mode_code;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    portmode_ctrl u_dut (
        .clk(clk), .rst(rst), .mode_pins(mode_pins), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .gpio_b_out(gbo), .gpio_b_dir(gbd), .gpio_c_out(gco), .gpio_c_dir(gcd),
        .gpio_f_out(gfo), .gpio_f_dir(gfd), .pc_in(pc_in),
        .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe),
        .pf_out(pf_out), .pf_oe(pf_oe), .rw_n(rw_n), .ext_rdata(ext_rdata),
        .boot_sel(boot_sel), .mode_valid(mode_valid), .mode_code(mode_code)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] addr;
        logic        we;
        logic [7:0]  wdata;
        logic [7:0]  pin;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'hBFFE, 1'b0, 8'h11, 8'h22},  // R8 vector area
        '{2'b00, 16'hBF00, 1'b1, 8'h33, 8'h44},  // R8 low edge
        '{2'b00, 16'hBEFF, 1'b0, 8'h55, 8'h66},  // R8 just below
        '{2'b00, 16'hC000, 1'b1, 8'h77, 8'h88},  // R8 just above
        '{2'b01, 16'hBFC0, 1'b0, 8'h99, 8'hA5},  // R7 R9
        '{2'b01, 16'h1234, 1'b1, 8'hAB, 8'h5C},  // R6
        '{2'b10, 16'hBFFF, 1'b1, 8'hCD, 8'h3E},  // R4 R9
        '{2'b10, 16'h0042, 1'b0, 8'hEF, 8'h7F},  // R4
        '{2'b11, 16'hBF80, 1'b1, 8'h01, 8'h80},  // R6 R9
        '{2'b11, 16'hFFFF, 1'b0, 8'hFE, 8'hC3},  // R5 R7
        '{2'b11, 16'h0000, 1'b1, 8'h00, 8'hFF},  // R5 R6
        '{2'b00, 16'h0100, 1'b1, 8'h5A, 8'h0F}   // R4 boot gpio
    };

    // Model: {pb_out,pb_oe,pc_out,pc_oe,pf_out,pf_oe,ext_rdata,rw_n,boot_sel}
    function automatic logic [57:0] model(input logic [1:0] m, input logic [15:0] a,
                                          input logic we, input logic [7:0] wd,
                                          input logic [7:0] pin);
        logic [7:0] b, bo, c, co, f, fo, rd;
        logic rw, bs;
        bs = (m == 2'b00) && (a[15:8] == 8'hBF);
        if (m[0]) begin
            b = a[15:8]; bo = 8'hFF; f = a[7:0]; fo = 8'hFF;
            rw = ~we;
            c  = we ? wd : 8'h00;
            co = we ? 8'hFF : 8'h00;
            rd = we ? 8'h00 : pin;
        end else begin
            b = gbo; bo = gbd; c = gco; co = gcd; f = gfo; fo = gfd;
            rw = 1'b1; rd = 8'h00;
        end
        return {b, bo, c, co, f, fo, rd, rw, bs};
    endfunction

    function automatic logic [57:0] observed();
        return {pb_out, pb_oe, pc_out, pc_oe, pf_out, pf_oe, ext_rdata, rw_n, boot_sel};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_mode(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1;
        mode_pins = m;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: quiet while in reset
        gbd = 8'hFF; gcd = 8'hFF; gfd = 8'hFF; cpu_we = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1", {pb_oe, pc_oe, pf_oe, rw_n, boot_sel, mode_valid},
              {24'h000000, 1'b1, 1'b0, 1'b0});

        // Table walk: one reset per vector
        for (int i = 0; i < NV; i++) begin
            start_mode(VECS[i].mode);
            gbo = VECS[i].wdata ^ 8'h3C; gbd = VECS[i].pin;
            gco = VECS[i].addr[7:0];     gcd = ~VECS[i].pin;
            gfo = VECS[i].addr[15:8];    gfd = VECS[i].wdata;
            cpu_addr = VECS[i].addr; cpu_we = VECS[i].we;
            cpu_wdata = VECS[i].wdata; pc_in = VECS[i].pin;
            #1;
            check("R2 latch", {mode_valid, mode_code}, {1'b1, VECS[i].mode});
            check("R4-R9 ports", observed(),
                  model(VECS[i].mode, VECS[i].addr, VECS[i].we, VECS[i].wdata, VECS[i].pin));
        end

        // R3: pins moved after latch have no effect
        start_mode(2'b10);
        mode_pins = 2'b01;
        cpu_addr = 16'hABCD; cpu_we = 1'b1; gbd = 8'h0F;
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        check("R3 code", {mode_valid, mode_code}, {1'b1, 2'b10});
        check("R3 ports", observed(), model(2'b10, 16'hABCD, 1'b1, cpu_wdata, pc_in));

        // R1: reassert reset from a bus mode; the edge sampling rst clears everything
        start_mode(2'b11);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk); #1;
        check("R1 re-reset", {pb_oe, pf_oe, mode_valid, rw_n}, {16'h0000, 1'b0, 1'b1});

        // R2: the code is taken on the release edge, not earlier
        mode_pins = 2'b00;
        @(negedge clk);
        mode_pins = 2'b11;
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk); #1;
        check("R2 release-edge", {mode_valid, mode_code}, {1'b1, 2'b11});

        // R8 + R4 same cycle: boot window hit while gpio drives
        start_mode(2'b00);
        gbo = 8'hA1; gbd = 8'h3C; gfo = 8'h7E; gfd = 8'hC3; gco = 8'h11; gcd = 8'h00;
        cpu_addr = 16'hBFFF; cpu_we = 1'b0; pc_in = 8'h99;
        #1;
        check("R8 R4 shared", observed(), model(2'b00, 16'hBFFF, 1'b0, cpu_wdata, 8'h99));

        // R7: read data follows the pins each cycle in test mode
        start_mode(2'b01);
        cpu_we = 1'b0;
        pc_in = 8'h3A;
        #1;
        check("R7 rdata a", {ext_rdata, rw_n}, {8'h3A, 1'b1});
        pc_in = 8'hC5;
        #1;
        check("R7 rdata b", {ext_rdata, rw_n}, {8'hC5, 1'b1});

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule